// File: doc/BRIEF.md
# Serial Control Register Port

This block is a three-line serial slave that lets a host processor read and update a bank of 32 eight-bit control registers. The host pulls the select line low, toggles the serial clock, and exchanges one 16-bit frame per selection. The frame starts with a fixed two-bit device identifier. A direction bit, a five-bit register index and a data byte follow it.

Write frames change the register bank when the select line is released, and only if exactly sixteen bits arrived. On a read frame the block turns the shared data line around after the index: it drives the addressed register's contents back, most significant bit first, and releases the line as soon as the select line rises. The whole bank is presented in parallel to the rest of the chip. All serial inputs are resynchronised to the system clock, and the pad output-enable is brought out so that the chip's I/O ring can build the shared pin.

Top module: `sctl_port`

## Requirements
- R1: While reset is held low, and right after it is released, register k holds its default value: the low 8 bits of (k*29) XOR 0xA5. For example, register 0 holds 0xA5 and register 5 holds 0x34.
- R2: The frame bits arrive on rising serial clock edges while select is low, in this order: a 2-bit identifier, then a direction bit (1 = write, 0 = read), then a 5-bit register index MSB first, then an 8-bit data byte MSB first.
- R3: A write frame commits its data byte to the indexed register when select rises. It does so only if exactly 16 rising clock edges arrived. A frame with fewer edges leaves every register unchanged.
- R4: A frame with more than 16 rising clock edges is discarded and changes no register.
- R5: A frame whose identifier is not binary 10 writes nothing and never enables the data output.
- R6: On a read frame with identifier 10, the output enable stays low during the 8 header bits. It rises after the first falling clock edge that follows the eighth rising edge. The output then presents the indexed register MSB first and advances one bit on each later falling edge.
- R7: The output enable is low whenever select has been high for the synchroniser delay plus one cycle.
- R8: A read frame leaves every register unchanged.
- R9: Raising select part way through a frame abandons it, and the next frame is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_cs_n | input | 1 | Serial select, low frames a transaction |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Value seen at the shared data pad |
| ser_dout | output | 1 | Read data to the shared data pad |
| ser_doe | output | 1 | Output enable for the shared data pad |
| cfg_q | output | 256 | All registers in parallel, register k at bits 8k+7..8k |

## Verification
The hardest situations to reach from the pins are frames whose length is off by one in either direction, and a select line that is released part way through a frame and followed at once by a valid frame. In all of these the bank must be left exactly as it was. The bench shifts every frame bit by bit with an explicit edge count. This lets it send 15, 8, 17 and 5-edge frames and then read back both the parallel bank and the serial read path.

// File: rtl/sctl_pkg.sv
// Package: shared types and reset-value rule for the serial control port.
// Assumes: data width is at most 32 bits.
package sctl_pkg;

    // Direction bit carried in each frame header.
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    // Default contents of register k after reset (truncated by the caller).
    function automatic logic [31:0] reset_value(input int unsigned k);
        logic [31:0] mix;
        mix = 32'(k * 29);
        return {mix[31:8], mix[7:0] ^ 8'hA5};
    endfunction

endpackage

// File: rtl/sctl_sync.sv
// Module: multi-stage synchroniser for a group of asynchronous inputs.
// Assumes: STAGES >= 2; bits are independent levels (no bus coherence needed).
module sctl_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], d};
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sctl_regbank.sv
// Module: bank of 2**ADDR_W registers with one write port, one read port
// and a parallel view of all contents.
// Assumes: write and read are on the system clock; reads are combinational.
module sctl_regbank #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NREG*DATA_W-1:0] cfg_q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DATA_W-1:0] r_q;

        // Hold one register: load its default on reset, take matching writes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                r_q <= DATA_W'(sctl_pkg::reset_value(i));
            else if (wr_en && wr_addr == ADDR_W'(i))
                r_q <= wr_data;
        end

        assign cfg_q[i*DATA_W +: DATA_W] = r_q;
    end

    // Select the register addressed by the read port.
    always_comb rd_data = cfg_q[rd_addr*DATA_W +: DATA_W];
endmodule

// File: rtl/sctl_frame.sv
// Module: frame decoder and read driver. Counts serial clock rises, collects
// header and data, issues a write on select release and shifts read data
// out on falling edges.
// Assumes: inputs are already synchronised to clk; the serial clock is slower
// than clk/4, so each serial edge is seen as one cycle of rise/fall.
module sctl_frame #(
    parameter int                CHIP_W  = 2,
    parameter int                ADDR_W  = 5,
    parameter int                DATA_W  = 8,
    parameter logic [CHIP_W-1:0] CHIP_ID = 2'b10,
    localparam int HDR_W = CHIP_W + 1 + ADDR_W,
    localparam int FRM_W = HDR_W + DATA_W,
    localparam int CNT_W = $clog2(FRM_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              doe,
    output logic [CHIP_W-1:0] hdr_chip,
    output logic              sclk_fall
);
    import sctl_pkg::*;

    logic              sclk_d, cs_d;
    logic              sclk_rise, cs_rise;
    logic [CNT_W-1:0]  cnt_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [DATA_W-1:0] dat_q;
    logic [DATA_W-1:0] tx_q;
    logic              hdr_match;
    dir_e              hdr_dir;

    // Remember the previous serial clock and select levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_n_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
    assign sclk_fall = ~sclk_s & sclk_d & ~cs_n_s;
    assign cs_rise   = cs_n_s & ~cs_d;

    assign hdr_chip  = hdr_q[HDR_W-1 -: CHIP_W];
    assign hdr_dir   = dir_e'(hdr_q[ADDR_W]);
    assign rd_addr   = hdr_q[ADDR_W-1:0];
    assign hdr_match = (hdr_chip == CHIP_ID);

    // Count rising edges within a frame; saturate one past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s)
            cnt_q <= '0;
        else if (sclk_rise && cnt_q != CNT_W'(FRM_W + 1))
            cnt_q <= cnt_q + 1'b1;
    end

    // Collect header bits during the first HDR_W rises.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hdr_q <= '0;
        else if (sclk_rise && cnt_q < CNT_W'(HDR_W))
            hdr_q <= {hdr_q[HDR_W-2:0], sdi_s};
    end

    // Collect data bits during the rises after the header.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dat_q <= '0;
        else if (sclk_rise && cnt_q >= CNT_W'(HDR_W) && cnt_q < CNT_W'(FRM_W))
            dat_q <= {dat_q[DATA_W-2:0], sdi_s};
    end

    // Issue a write when select rises after exactly one full write frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= cs_rise && cnt_q == CNT_W'(FRM_W) && hdr_match
                       && hdr_dir == DIR_WRITE;
            wr_addr <= rd_addr;
            wr_data <= dat_q;
        end
    end

    // Turn the line around after the header of a matching read, then shift.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            doe  <= 1'b0;
            tx_q <= '0;
        end else if (sclk_fall) begin
            if (doe)
                tx_q <= {tx_q[DATA_W-2:0], 1'b0};
            else if (cnt_q == CNT_W'(HDR_W) && hdr_match && hdr_dir == DIR_READ) begin
                doe  <= 1'b1;
                tx_q <= rd_data;
            end
        end
    end

    assign sdo = tx_q[DATA_W-1];
endmodule

// File: rtl/sctl_port.sv
// Module: top of the serial control port. Synchronises the three serial
// lines, decodes frames and owns the register bank.
// Assumes: serial clock well below clk/4; pad is built outside from
// ser_dout/ser_doe and its level fed back on ser_din.
module sctl_port #(
    parameter int                CHIP_W      = 2,
    parameter int                ADDR_W      = 5,
    parameter int                DATA_W      = 8,
    parameter logic [CHIP_W-1:0] CHIP_ID     = 2'b10,
    parameter int                SYNC_STAGES = 2,
    localparam int NREG = 1 << ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_cs_n,
    input  logic                   ser_clk,
    input  logic                   ser_din,
    output logic                   ser_dout,
    output logic                   ser_doe,
    output logic [NREG*DATA_W-1:0] cfg_q
);
    logic              cs_n_s, sclk_s, sdi_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;
    logic [CHIP_W-1:0] hdr_chip;
    logic              sclk_fall;

    sctl_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_cs_n, ser_clk, ser_din}),
        .q     ({cs_n_s, sclk_s, sdi_s})
    );

    sctl_frame #(
        .CHIP_W  (CHIP_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CHIP_ID (CHIP_ID)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sclk_s    (sclk_s),
        .sdi_s     (sdi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdo       (ser_dout),
        .doe       (ser_doe),
        .hdr_chip  (hdr_chip),
        .sclk_fall (sclk_fall)
    );

    sctl_regbank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_q   (cfg_q)
    );
endmodule

// File: rtl/sctl_port_chk.sv
// Module: assertion checker for sctl_port, attached by bind.
// Assumes: connected to the top's synchronised select, decoded strobes and
// pad outputs.
module sctl_port_chk #(
    parameter int                CHIP_W  = 2,
    parameter int                ADDR_W  = 5,
    parameter int                DATA_W  = 8,
    parameter logic [CHIP_W-1:0] CHIP_ID = 2'b10,
    localparam int NREG = 1 << ADDR_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs_n_s,
    input logic                   sclk_fall,
    input logic                   doe,
    input logic                   sdo,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [DATA_W-1:0]      wr_data,
    input logic [CHIP_W-1:0]      hdr_chip,
    input logic [NREG*DATA_W-1:0] cfg_q
);
    logic              wen_q;
    logic [ADDR_W-1:0] wa_q;
    logic [DATA_W-1:0] wd_q;

    // Remember the last write strobe so its effect on the bank can be checked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q <= 1'b0;
            wa_q  <= '0;
            wd_q  <= '0;
        end else begin
            wen_q <= wr_en;
            wa_q  <= wr_addr;
            wd_q  <= wr_data;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wen_q |-> cfg_q[wa_q*DATA_W +: DATA_W] == wd_q); // R3
    AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q)); // R5
    AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> !doe); // R7
    AST_OE_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (doe && $past(doe) && !$past(sclk_fall)) |-> $stable(sdo)); // R6
    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        doe |-> !wr_en); // R8
    AST_OE_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(doe) |-> hdr_chip == CHIP_ID); // R5
endmodule

bind sctl_port sctl_port_chk #(
    .CHIP_W  (CHIP_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CHIP_ID (CHIP_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .sclk_fall (sclk_fall),
    .doe       (ser_doe),
    .sdo       (ser_dout),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hdr_chip  (hdr_chip),
    .cfg_q     (cfg_q)
);

// File: tb/sctl_port_bench.sv
// Bench: directed scenarios for sctl_port, one task each.
module sctl_port_bench;
    localparam int H = 8;   // system cycles per serial half-phase

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_cs_n = 1'b1;
    logic         ser_clk = 1'b0;
    logic         host_din = 1'b0;
    logic         pad;
    logic         ser_dout, ser_doe;
    logic [255:0] cfg_q;
    int           n_vec = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    assign pad = ser_doe ? ser_dout : host_din;

    sctl_port u_sctl_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_cs_n (ser_cs_n),
        .ser_clk  (ser_clk),
        .ser_din  (pad),
        .ser_dout (ser_dout),
        .ser_doe  (ser_doe),
        .cfg_q    (cfg_q)
    );

    function automatic logic [7:0] dflt(input int k);
        return 8'((k * 29) & 255) ^ 8'hA5;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift one frame of nbits edges; capture read bits and enable behaviour.
    task automatic xfer(input logic [1:0] id, input logic dir, input logic [4:0] a,
                        input logic [7:0] d, input int nbits, output logic [7:0] rbits,
                        output logic oe_hdr, output logic oe_dat, output logic oe_after);
        logic [15:0] frame;
        frame = {id, dir, a, d};
        rbits = '0; oe_hdr = 1'b0; oe_dat = 1'b1;
        wt(1);
        ser_cs_n = 1'b0;
        wt(H);
        for (int i = 0; i < nbits; i++) begin
            if (i < 8) oe_hdr = oe_hdr | ser_doe;
            else if (i < 16) begin
                oe_dat = oe_dat & ser_doe;
                rbits[15-i] = pad;
            end
            host_din = (i < 16) ? frame[15-i] : 1'b0;
            wt(H); ser_clk = 1'b1;
            wt(H); ser_clk = 1'b0;
            wt(H);
        end
        ser_cs_n = 1'b1;
        host_din = 1'b0;
        wt(8);
        oe_after = ser_doe;
        wt(H);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] r; logic h, o, f;
        xfer(2'b10, 1'b1, a, d, 16, r, h, o, f);
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d, output logic ok);
        logic h, o, f;
        xfer(2'b10, 1'b0, a, 8'h00, 16, d, h, o, f);
        ok = !h && o && !f;
    endtask

    task automatic t_reset;
        wt(3);
        chk({7'd0, ser_doe}, 8'h00, "R1 enable low in reset");
        chk(cfg_q[7:0], 8'hA5, "R1 reg0 during reset");
        rst_n = 1'b1;
        wt(4);
        for (int k = 0; k < 32; k++) chk(cfg_q[k*8 +: 8], dflt(k), "R1 default after reset");
    endtask

    task automatic t_write_read;
        logic [7:0] r; logic ok;
        wr(5'd5, 8'h3C);
        chk(cfg_q[5*8 +: 8], 8'h3C, "R2 write reg5");
        chk(cfg_q[6*8 +: 8], dflt(6), "R2 neighbour untouched");
        wr(5'd31, 8'h81);
        wr(5'd0, 8'hFF);
        chk(cfg_q[31*8 +: 8], 8'h81, "R2 write reg31");
        chk(cfg_q[7:0], 8'hFF, "R2 write reg0");
        rd(5'd5, r, ok);
        chk(r, 8'h3C, "R6 read reg5 data");
        chk({7'd0, ok}, 8'h01, "R6 enable window reg5");
        rd(5'd31, r, ok);
        chk(r, 8'h81, "R6 read reg31 data");
        rd(5'd3, r, ok);
        chk(r, dflt(3), "R6 read default reg3");
    endtask

    task automatic t_short;
        logic [7:0] r; logic h, o, f;
        xfer(2'b10, 1'b1, 5'd9, 8'h77, 15, r, h, o, f);
        chk(cfg_q[9*8 +: 8], dflt(9), "R3 15-edge frame discarded");
        xfer(2'b10, 1'b1, 5'd9, 8'h77, 8, r, h, o, f);
        chk(cfg_q[9*8 +: 8], dflt(9), "R3 8-edge frame discarded");
    endtask

    task automatic t_long;
        logic [7:0] r; logic h, o, f;
        xfer(2'b10, 1'b1, 5'd10, 8'h66, 17, r, h, o, f);
        chk(cfg_q[10*8 +: 8], dflt(10), "R4 17-edge frame discarded");
    endtask

    task automatic t_bad_id;
        logic [7:0] r; logic h, o, f;
        xfer(2'b01, 1'b1, 5'd9, 8'h12, 16, r, h, o, f);
        chk(cfg_q[9*8 +: 8], dflt(9), "R5 id 01 write ignored");
        xfer(2'b11, 1'b0, 5'd5, 8'h00, 16, r, h, o, f);
        chk({6'd0, h, o}, 8'h00, "R5 id 11 read never drives");
    endtask

    task automatic t_read_clean;
        logic [7:0] r; logic h, o, f;
        xfer(2'b10, 1'b0, 5'd5, 8'hC3, 16, r, h, o, f);
        chk({7'd0, h}, 8'h00, "R6 no drive during header");
        chk({7'd0, f}, 8'h00, "R7 released after select high");
        chk(cfg_q[5*8 +: 8], 8'h3C, "R8 read leaves reg5");
    endtask

    task automatic t_restart;
        logic [7:0] r; logic h, o, f;
        xfer(2'b10, 1'b1, 5'd12, 8'hEE, 5, r, h, o, f);
        wr(5'd12, 8'h5A);
        chk(cfg_q[12*8 +: 8], 8'h5A, "R9 frame after abort decoded");
    endtask

    initial begin
        t_reset;
        t_write_read;
        t_short;
        t_long;
        t_bad_id;
        t_read_clean;
        t_restart;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule